// File: doc/BRIEF.md
# Reset Startup Sequencer

This block sits between the external active-low reset pin of a small processor core and the core itself. It brings the pin into the clock domain through a two-flop synchronizer. It accepts a reset only when the synchronized pin has stayed low for a minimum number of state times, so short glitches are ignored. While a reset is accepted the core is held stopped.

When the pin returns high, the block restarts its divide-by-two clock output in a known phase. It then steps through a fixed ten-state-time boot sequence. The sequence clears the core's status word, reads one configuration byte from a fixed memory address into a configuration register, and loads the program counter with a fixed start address. A running flag goes high once that load has happened. One state time is two input clock cycles. The memory answers a read within the two state times the request is held.

Top module: `reset_boot_seq`

## Requirements
- R1: While `rst_ni` is low, and afterwards for as long as the synchronized reset pin stays low, `running_o`, `status_clr_o`, `rd_req_o` and `pc_load_o` are 0, `rd_addr_o` is 0 and `cfg_o` is 0.
- R2: A low level on `rst_pin_ni` seen at 8 or more consecutive clock edges (4 state times) is accepted as a reset. `running_o` drops 10 clock cycles after the pin first falls: 2 cycles of synchronizer and 8 of low-time count.
- R3: A low pulse on `rst_pin_ni` seen at 7 or fewer consecutive clock edges is ignored. `running_o` stays 1 and no sequence output strobes.
- R4: The boot sequence starts on the third clock edge after the pin rises. In its first cycle `clk_out_o` is 0, and it then toggles every cycle, giving a divide-by-two clock with 50% duty cycle.
- R5: The boot sequence lasts exactly 20 clock cycles (10 state times). `running_o` is 1 from the cycle after it ends.
- R6: `status_clr_o` is 1 during the first state time of the sequence (cycles 0 and 1) and 0 elsewhere.
- R7: During state times 2 and 3 (cycles 4 to 7), `rd_req_o` is 1 with `rd_addr_o` = 0x2018. `rd_addr_o` is 0 whenever `rd_req_o` is 0. `cfg_o` takes the `rd_data_i` value sampled at the end of cycle 7 and changes at no other time.
- R8: `pc_load_o` is a single-cycle pulse in the last cycle of the sequence (cycle 19), with `pc_o` = 0x2080. `running_o` rises on the next cycle and never rises without that pulse.
- R9: An accepted reset during the boot sequence aborts it with no `pc_load_o` pulse. The next release runs the whole sequence again from cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block itself |
| rst_pin_ni | input | 1 | External active-low reset pin, asynchronous |
| rd_data_i | input | 8 | Configuration byte returned by memory |
| clk_out_o | output | 1 | Input clock divided by two, resynchronized on release |
| status_clr_o | output | 1 | Clears the core's status word |
| rd_req_o | output | 1 | Memory read request for the configuration byte |
| rd_addr_o | output | 16 | Read address; fixed configuration address while requested |
| cfg_o | output | 8 | Configuration register |
| pc_load_o | output | 1 | One-cycle program-counter load strobe |
| pc_o | output | 16 | Start address to load into the program counter |
| running_o | output | 1 | Core may execute |

## Verification
The boot sequence is exercised from three entry points: a power-up release, a release after an accepted reset pulse taken while running, and a restart after a reset that aborted a sequence midway. A different configuration byte is used each time, so a stale or early load of `cfg_o` is visible. Reset pulses of 7 and 8 sampled cycles distinguish a filter whose threshold is off by one from a correct one. The mid-sequence reset falls after the read but before the jump, which separates a sequencer that honours the abort from one that completes the pending program-counter load.

// File: rtl/reset_seq_pkg.sv
package reset_seq_pkg;
  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_SEQ  = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int unsigned MIN_LOW_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic pin_s_o,
  output logic accept_o
);
  localparam int unsigned CNT_W = (MIN_LOW_CYC > 2) ? $clog2(MIN_LOW_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_LOW_CYC - 1);

  logic [1:0]       sync_q;
  logic [CNT_W-1:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], pin_ni};
  end

  assign pin_s_o = sync_q[1];

  // saturate so accept stays high while the pin is held low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   low_cnt_q <= '0;
    else if (pin_s_o)              low_cnt_q <= '0;
    else if (low_cnt_q != CNT_MAX) low_cnt_q <= low_cnt_q + 1'b1;
  end

  assign accept_o = !pin_s_o && (low_cnt_q == CNT_MAX);

  assert_high_clears_accept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_s_o |=> !accept_o);
  assert_accept_after_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(accept_o) |-> $past(!pin_s_o));
endmodule

// File: rtl/state_clock.sv
module state_clock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic resync_i,
  output logic clk_out_o,
  output logic state_end_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       phase_q <= 1'b0;
    else if (resync_i) phase_q <= 1'b0;
    else               phase_q <= ~phase_q;
  end

  assign clk_out_o   = phase_q;
  assign state_end_o = phase_q;

  assert_resync_low_phase_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_i |=> !clk_out_o);
  assert_free_toggle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resync_i |=> (clk_out_o != $past(clk_out_o)));
endmodule

// File: rtl/boot_ctrl.sv
module boot_ctrl
  import reset_seq_pkg::*;
#(
  parameter int unsigned SEQ_STATES = 10,
  parameter int unsigned CLR_STATE  = 0,
  parameter int unsigned RD_FIRST   = 2,
  parameter int unsigned RD_LAST    = 3,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR   = 16'h2018,
  parameter logic [ADDR_W-1:0] START_ADDR = 16'h2080
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_s_i,
  input  logic              accept_i,
  input  logic              state_end_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              resync_o,
  output logic              status_clr_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [DATA_W-1:0] cfg_o,
  output logic              pc_load_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              running_o
);
  localparam int unsigned ST_W = $clog2(SEQ_STATES);
  localparam logic [ST_W-1:0] LAST_ST = ST_W'(SEQ_STATES - 1);
  localparam logic [ST_W-1:0] CLR_ST  = ST_W'(CLR_STATE);
  localparam logic [ST_W-1:0] RD_LO   = ST_W'(RD_FIRST);
  localparam logic [ST_W-1:0] RD_HI   = ST_W'(RD_LAST);

  seq_state_e      state_q, state_d;
  logic [ST_W-1:0] st_cnt_q, st_cnt_d;
  logic [DATA_W-1:0] cfg_q;
  logic            in_seq, cfg_load;

  assign in_seq   = (state_q == ST_SEQ);
  assign resync_o = (state_q == ST_HOLD) && pin_s_i;

  always_comb begin
    state_d  = state_q;
    st_cnt_d = st_cnt_q;
    if (accept_i) begin
      state_d  = ST_HOLD;
      st_cnt_d = '0;
    end else begin
      unique case (state_q)
        ST_HOLD: if (pin_s_i) begin
          state_d  = ST_SEQ;
          st_cnt_d = '0;
        end
        ST_SEQ: if (state_end_i) begin
          if (st_cnt_q == LAST_ST) state_d = ST_RUN;
          else                     st_cnt_d = st_cnt_q + 1'b1;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_HOLD;
      st_cnt_q <= '0;
    end else begin
      state_q  <= state_d;
      st_cnt_q <= st_cnt_d;
    end
  end

  assign cfg_load = in_seq && state_end_i && (st_cnt_q == RD_HI) && !accept_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_load) cfg_q <= rd_data_i;
  end

  assign status_clr_o = in_seq && (st_cnt_q == CLR_ST);
  assign rd_req_o     = in_seq && (st_cnt_q >= RD_LO) && (st_cnt_q <= RD_HI);
  assign rd_addr_o    = rd_req_o ? CFG_ADDR : '0;
  assign cfg_o        = cfg_q;
  assign pc_load_o    = in_seq && state_end_i && (st_cnt_q == LAST_ST) && !accept_i;
  assign pc_o         = START_ADDR;
  assign running_o    = (state_q == ST_RUN);

  assert_accept_stops_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> !running_o);
  assert_cnt_in_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_seq |-> (st_cnt_q <= LAST_ST));
  assert_clr_read_apart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_clr_o && rd_req_o));
  assert_cfg_only_after_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_o) |-> $past(rd_req_o));
  assert_load_then_run_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |=> running_o);
  assert_run_needs_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(running_o) |-> $past(pc_load_o));
  assert_pc_load_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |=> !pc_load_o);
endmodule

// File: rtl/reset_boot_seq.sv
module reset_boot_seq #(
  parameter int unsigned MIN_LOW_STATES = 4,
  parameter int unsigned SEQ_STATES     = 10,
  parameter int unsigned ADDR_W         = 16,
  parameter int unsigned DATA_W         = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR   = 16'h2018,
  parameter logic [ADDR_W-1:0] START_ADDR = 16'h2080
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rst_pin_ni,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              clk_out_o,
  output logic              status_clr_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [DATA_W-1:0] cfg_o,
  output logic              pc_load_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              running_o
);
  localparam int unsigned CYC_PER_STATE = 2;
  localparam int unsigned MIN_LOW_CYC   = MIN_LOW_STATES * CYC_PER_STATE;

  logic pin_s, accept, resync, state_end;

  rst_pin_filter #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_filter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_ni   (rst_pin_ni),
    .pin_s_o  (pin_s),
    .accept_o (accept)
  );

  state_clock u_clk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .resync_i    (resync),
    .clk_out_o   (clk_out_o),
    .state_end_o (state_end)
  );

  boot_ctrl #(
    .SEQ_STATES (SEQ_STATES),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .CFG_ADDR   (CFG_ADDR),
    .START_ADDR (START_ADDR)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pin_s_i      (pin_s),
    .accept_i     (accept),
    .state_end_i  (state_end),
    .rd_data_i    (rd_data_i),
    .resync_o     (resync),
    .status_clr_o (status_clr_o),
    .rd_req_o     (rd_req_o),
    .rd_addr_o    (rd_addr_o),
    .cfg_o        (cfg_o),
    .pc_load_o    (pc_load_o),
    .pc_o         (pc_o),
    .running_o    (running_o)
  );
endmodule

// File: tb/reset_boot_seq_tb_top.sv
module reset_boot_seq_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rst_pin_ni = 1'b0;
  logic [7:0]  rd_data = 8'h00;
  logic        clk_out_o, status_clr_o, rd_req_o, pc_load_o, running_o;
  logic [15:0] rd_addr_o, pc_o;
  logic [7:0]  cfg_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_cfg = 8'h00;

  typedef struct {
    bit         care_clk;
    bit         clk;
    bit         sclr;
    bit         rreq;
    bit         pcl;
    bit         run;
    logic [7:0] cfg;
  } exp_t;

  exp_t exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  reset_boot_seq dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .rst_pin_ni   (rst_pin_ni),
    .rd_data_i    (rd_data),
    .clk_out_o    (clk_out_o),
    .status_clr_o (status_clr_o),
    .rd_req_o     (rd_req_o),
    .rd_addr_o    (rd_addr_o),
    .cfg_o        (cfg_o),
    .pc_load_o    (pc_load_o),
    .pc_o         (pc_o),
    .running_o    (running_o)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: one expected record per cycle, sampled a quarter period after the edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.care_clk) chk("R4", "clk_out_o", 16'(clk_out_o), 16'(e.clk));
        chk("R6", "status_clr_o", 16'(status_clr_o), 16'(e.sclr));
        chk("R7", "rd_req_o", 16'(rd_req_o), 16'(e.rreq));
        chk("R7", "rd_addr_o", rd_addr_o, e.rreq ? 16'h2018 : 16'h0000);
        chk("R7", "cfg_o", 16'(cfg_o), 16'(e.cfg));
        chk("R8", "pc_load_o", 16'(pc_load_o), 16'(e.pcl));
        if (e.pcl) chk("R8", "pc_o", pc_o, 16'h2080);
        chk("R5", "running_o", 16'(running_o), 16'(e.run));
      end
    end
  end

  task automatic push(input bit care_clk, input bit c, input bit s, input bit r,
                      input bit p, input bit run, input logic [7:0] cfg);
    exp_t e;
    e.care_clk = care_clk; e.clk = c; e.sclr = s; e.rreq = r;
    e.pcl = p; e.run = run; e.cfg = cfg;
    exp_q.push_back(e);
  endtask

  task automatic wait_idle();
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  // driver: release the pin and queue the full expected boot sequence
  task automatic boot(input bit was_running, input logic [7:0] data);
    rd_data = data;
    rst_pin_ni = 1'b1;
    push(0, 0, 0, 0, 0, was_running, exp_cfg);
    push(0, 0, 0, 0, 0, 0, exp_cfg);
    for (int k = 0; k < 20; k++)
      push(1, 1'(k % 2), k < 2, (k >= 4) && (k <= 7), k == 19, 0, (k >= 8) ? data : exp_cfg);
    push(0, 0, 0, 0, 0, 1, data);
    exp_cfg = data;
  endtask

  // pulse the pin low for len cycles while running
  task automatic pulse(input int len, input logic [7:0] data);
    wait_idle();
    rst_pin_ni = 1'b0;
    for (int i = 0; i < len; i++) push(0, 0, 0, 0, 0, 1, exp_cfg);
    repeat (len) @(negedge clk);
    if (len >= 8) begin
      boot(1, data);                                  // R2: accepted, reboots
    end else begin
      rst_pin_ni = 1'b1;
      for (int i = 0; i < 14; i++) push(0, 0, 0, 0, 0, 1, exp_cfg);  // R3: ignored
    end
    wait_idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int pcl_seen;
    repeat (3) @(negedge clk);
    // R1: during block reset
    chk("R1", "running_o", 16'(running_o), 16'h0);
    chk("R1", "rd_addr_o", rd_addr_o, 16'h0);
    chk("R1", "cfg_o", 16'(cfg_o), 16'h0);
    rst_ni = 1'b1;
    repeat (12) @(negedge clk);
    // R1: pin still low after reset release keeps the core held
    chk("R1", "running_o held", 16'(running_o), 16'h0);
    chk("R1", "status_clr_o held", 16'(status_clr_o), 16'h0);
    chk("R1", "rd_req_o held", 16'(rd_req_o), 16'h0);
    chk("R1", "pc_load_o held", 16'(pc_load_o), 16'h0);

    boot(0, 8'hA5);                                   // R4..R8 from power-up
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R5", "running_o steady", 16'(running_o), 16'h1);

    pulse(7, 8'h11);                                  // R3: too short
    chk("R3", "cfg_o unchanged", 16'(cfg_o), 16'hA5);
    pulse(8, 8'h5A);                                  // R2: minimum accepted length
    chk("R2", "cfg_o reloaded", 16'(cfg_o), 16'h5A);

    // R9: reset accepted mid-sequence aborts it
    rst_pin_ni = 1'b0;
    repeat (12) @(negedge clk);
    chk("R2", "running_o after long low", 16'(running_o), 16'h0);
    rd_data = 8'h3C;
    rst_pin_ni = 1'b1;
    repeat (7) @(negedge clk);                       // sequence cycle 4
    rst_pin_ni = 1'b0;
    pcl_seen = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (pc_load_o) pcl_seen++;
      chk("R9", "running_o during abort", 16'(running_o), 16'h0);
    end
    chk("R9", "pc_load_o pulses in aborted run", 16'(pcl_seen), 16'h0);
    exp_cfg = 8'h3C;                                  // read completed before the abort
    boot(0, 8'h96);                                   // R9: full restart from cycle 0
    wait_idle();
    repeat (2) @(negedge clk);
    chk("R9", "running_o after restart", 16'(running_o), 16'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule